// File: doc/BRIEF.md
# Card Controller Register and Interrupt Unit

This block is the software-visible face of a memory card host controller. It sits on a simple single-cycle read/write bus in a 4 KB window. It holds the configuration that the command and data engines use: supply control, bus clock divider, command argument, command word, data timeout, transfer length and data control. It keeps the response words and the count of bytes still to move. It also collects the engines' event bits into a status word that software can clear.

The engines sit outside the block and are joined to it by strobes. A command write that has the go bit set produces a one-cycle start pulse. A data-control write that has the enable bit set reloads the byte counter and produces a start pulse. Each transferred byte decrements the counter. A response strobe captures the response index and four response words. Accesses to the FIFO data window turn into push and pop strobes towards an external FIFO. Two interrupt lines are formed from the status word and two independent mask registers. A fixed run of identification bytes at the top of the window lets software recognise the block. Undefined offsets return zero and raise a bus error indication.

Top module: `card_regs`

## Requirements
- R1: After reset every readable register reads zero, and both interrupt lines are low.
- R2: The supply register (0x00), the clock register (0x04) and the data control register (0x2C) keep only bits [7:0]. The length register (0x28) keeps bits [15:0]. The argument register (0x08) and the timer register (0x24) keep all 32 bits. Each of these reads back what it keeps, with the upper bits reading zero.
- R3: A write to 0x0C stores bits [10:0]. When written bit 10 (go) is 1, cmd_start is high for exactly the one cycle after the write, and the stored bit 10 reads back 0. With bit 10 at 0, no pulse is produced.
- R4: A resp_load strobe captures resp_cmd, which reads at 0x10. It also captures the four response words, which read at 0x14, 0x18, 0x1C and 0x20; word 0 is resp_data[31:0].
- R5: Status (0x34) reads live_status in bits [21:11] and sticky event bits in bits [10:0]. An evt_set bit sets its sticky bit. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R6: A write to 0x38 clears the sticky bits that are 1 in wdata[10:0]. Written bits above bit 10 have no effect, and 0x38 reads zero.
- R7: irq[i] is high exactly when (status AND mask i) is nonzero. Mask 0 is at 0x3C and mask 1 is at 0x40, both 32 bits.
- R8: A write to 0x2C with bit 0 set loads the data count (0x30) from the length and pulses data_start in the next cycle. Each byte_done decrements the count, and the count holds at zero. A load wins over a decrement in the same cycle.
- R9: 0x48 reads (data count + 3) >> 2.
- R10: A read of any word offset from 0x80 to 0xBC returns fifo_rdata and pulses fifo_pop in the same cycle. When fifo_empty is high, the read returns 0 and no pop occurs.
- R11: A write to the FIFO window drives fifo_push with fifo_wdata equal to the written word, but only while the data count is nonzero.
- R12: Word offsets 0xFE0 to 0xFFC read the bytes 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in address order and one per word.
- R13: Any other offset, including an unaligned one, reads 0, raises bus_err during the access, and a write to it changes nothing. Writes to the read-only offsets 0x10 to 0x20, 0x30, 0x34 and 0x48 are ignored without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Undefined offset accessed |
| power_out | output | 8 | Supply control value |
| clkdiv_out | output | 8 | Clock control value |
| cmd_arg | output | 32 | Command argument |
| cmd_value | output | 11 | Stored command word |
| cmd_start | output | 1 | Command go pulse |
| data_timer | output | 32 | Data timeout value |
| data_ctrl | output | 8 | Data control value |
| data_start | output | 1 | Data transfer start pulse |
| resp_load | input | 1 | Capture response strobe |
| resp_cmd | input | 6 | Response command index |
| resp_data | input | 128 | Response words 3..0 |
| evt_set | input | 11 | Sticky status set pulses |
| live_status | input | 11 | Level status bits 21..11 |
| byte_done | input | 1 | One byte transferred |
| fifo_rdata | input | 32 | FIFO head word |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_push | output | 1 | Push strobe |
| fifo_pop | output | 1 | Pop strobe |
| fifo_wdata | output | 32 | Word to push |
| irq | output | 2 | Interrupt lines |

## Verification
Some properties are checked on every cycle. No push occurs while the byte count is zero, and no pop occurs from an empty FIFO. Each command pulse traces back to a go write. A clear leaves none of its bits set unless the same cycle also set them. Event pulses stick, the counter steps down by one per byte, error reads return zero, and zero masks keep the interrupts quiet. Other behaviour needs the bench's scenarios to show it: the width trimming of each register, the capture of responses, the set-over-clear race, the FIFO count rounding at one and at full length, the alias range of the FIFO window, the identification bytes, and the fact that ignored writes leave state untouched.

// File: rtl/cardreg_pkg.sv
package cardreg_pkg;

  typedef enum logic [4:0] {
    RS_POWER, RS_CLOCK, RS_ARG, RS_CMD, RS_RCMD, RS_RESP, RS_DTIMER,
    RS_DLEN, RS_DCTRL, RS_DCNT, RS_STAT, RS_CLR, RS_MASK, RS_FCNT,
    RS_FIFO, RS_ID, RS_NONE
  } reg_sel_e;

  localparam logic [6:0] OFF_POWER  = 7'h00;
  localparam logic [6:0] OFF_CLOCK  = 7'h04;
  localparam logic [6:0] OFF_ARG    = 7'h08;
  localparam logic [6:0] OFF_CMD    = 7'h0C;
  localparam logic [6:0] OFF_RCMD   = 7'h10;
  localparam logic [6:0] OFF_RESP0  = 7'h14;
  localparam logic [6:0] OFF_RESP3  = 7'h20;
  localparam logic [6:0] OFF_DTIMER = 7'h24;
  localparam logic [6:0] OFF_DLEN   = 7'h28;
  localparam logic [6:0] OFF_DCTRL  = 7'h2C;
  localparam logic [6:0] OFF_DCNT   = 7'h30;
  localparam logic [6:0] OFF_STAT   = 7'h34;
  localparam logic [6:0] OFF_CLR    = 7'h38;
  localparam logic [6:0] OFF_MASK0  = 7'h3C;
  localparam logic [6:0] OFF_MASK1  = 7'h40;
  localparam logic [6:0] OFF_FCNT   = 7'h48;

  localparam int CMD_GO_BIT   = 10;
  localparam int DATA_EN_BIT  = 0;

  // Number of FIFO words still covering the remaining byte count.
  function automatic logic [31:0] fifo_words(input logic [31:0] bytes_left);
    logic [32:0] sum;
    sum = {1'b0, bytes_left} + 33'd3;
    return sum[33-1:2] & 32'h7FFF_FFFF;
  endfunction

  // Identification byte for word slot 0..7 of the top window.
  function automatic logic [7:0] id_byte(input logic [2:0] slot);
    case (slot)
      3'd0: return 8'h81;
      3'd1: return 8'h11;
      3'd2: return 8'h04;
      3'd3: return 8'h00;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/cardreg_decode.sv
module cardreg_decode
  import cardreg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [2:0]        idx
);

  logic [4:0] word_no;
  assign word_no = addr[6:2];

  always_comb begin
    sel = RS_NONE;
    idx = '0;
    if (addr[1:0] == 2'b00) begin
      if (&addr[ADDR_W-1:5]) begin
        sel = RS_ID;
        idx = addr[4:2];
      end else if (addr[ADDR_W-1:6] == (ADDR_W-6)'(2)) begin
        sel = RS_FIFO;
      end else if (addr[ADDR_W-1:7] == '0) begin
        if (addr[6:0] >= OFF_RESP0 && addr[6:0] <= OFF_RESP3) begin
          sel = RS_RESP;
          idx = 3'(word_no - 5'd5);
        end else begin
          case (addr[6:0])
            OFF_POWER:  sel = RS_POWER;
            OFF_CLOCK:  sel = RS_CLOCK;
            OFF_ARG:    sel = RS_ARG;
            OFF_CMD:    sel = RS_CMD;
            OFF_RCMD:   sel = RS_RCMD;
            OFF_DTIMER: sel = RS_DTIMER;
            OFF_DLEN:   sel = RS_DLEN;
            OFF_DCTRL:  sel = RS_DCTRL;
            OFF_DCNT:   sel = RS_DCNT;
            OFF_STAT:   sel = RS_STAT;
            OFF_CLR:    sel = RS_CLR;
            OFF_MASK0:  begin sel = RS_MASK; idx = 3'd0; end
            OFF_MASK1:  begin sel = RS_MASK; idx = 3'd1; end
            OFF_FCNT:   sel = RS_FCNT;
            default:    sel = RS_NONE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/cardreg_cfg.sv
module cardreg_cfg
  import cardreg_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CTRL_W     = 8,
  parameter int LEN_W      = 16,
  parameter int CMD_W      = 11,
  parameter int RCMD_W     = 6,
  parameter int RESP_WORDS = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 we,
  input  reg_sel_e                             sel,
  input  logic [DATA_W-1:0]                    wdata,
  input  logic                                 resp_load,
  input  logic [RCMD_W-1:0]                    resp_cmd,
  input  logic [RESP_WORDS-1:0][DATA_W-1:0]    resp_data,
  input  logic                                 byte_done,
  output logic [CTRL_W-1:0]                    power_q,
  output logic [CTRL_W-1:0]                    clk_q,
  output logic [DATA_W-1:0]                    arg_q,
  output logic [CMD_W-1:0]                     cmd_q,
  output logic [DATA_W-1:0]                    dtimer_q,
  output logic [LEN_W-1:0]                     dlen_q,
  output logic [CTRL_W-1:0]                    dctrl_q,
  output logic [LEN_W-1:0]                     dcnt_q,
  output logic [RCMD_W-1:0]                    rcmd_q,
  output logic [RESP_WORDS-1:0][DATA_W-1:0]    resp_q,
  output logic                                 cmd_start,
  output logic                                 data_start,
  output logic                                 dcnt_load
);

  localparam logic [CMD_W-1:0] GO_MASK = CMD_W'(1) << CMD_GO_BIT;

  logic cmd_go;
  assign cmd_go    = we && (sel == RS_CMD) && wdata[CMD_GO_BIT];
  assign dcnt_load = we && (sel == RS_DCTRL) && wdata[DATA_EN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      power_q    <= '0;
      clk_q      <= '0;
      arg_q      <= '0;
      cmd_q      <= '0;
      dtimer_q   <= '0;
      dlen_q     <= '0;
      dctrl_q    <= '0;
      cmd_start  <= 1'b0;
      data_start <= 1'b0;
    end else begin
      cmd_start  <= cmd_go;
      data_start <= dcnt_load;
      if (we) begin
        case (sel)
          RS_POWER:  power_q  <= wdata[CTRL_W-1:0];
          RS_CLOCK:  clk_q    <= wdata[CTRL_W-1:0];
          RS_ARG:    arg_q    <= wdata;
          RS_CMD:    cmd_q    <= wdata[CMD_W-1:0] & ~GO_MASK;
          RS_DTIMER: dtimer_q <= wdata;
          RS_DLEN:   dlen_q   <= wdata[LEN_W-1:0];
          RS_DCTRL:  dctrl_q  <= wdata[CTRL_W-1:0];
          default:   ;
        endcase
      end
    end
  end

  // Byte counter: reload wins over a same-cycle decrement.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt_q <= '0;
    end else if (dcnt_load) begin
      dcnt_q <= dlen_q;
    end else if (byte_done && (dcnt_q != '0)) begin
      dcnt_q <= dcnt_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcmd_q <= '0;
      resp_q <= '0;
    end else if (resp_load) begin
      rcmd_q <= resp_cmd;
      resp_q <= resp_data;
    end
  end

endmodule

// File: rtl/cardreg_status.sv
module cardreg_status #(
  parameter int DATA_W  = 32,
  parameter int EVT_W   = 11,
  parameter int LIVE_W  = 11,
  parameter int NUM_IRQ = 2,
  localparam int STAT_W = EVT_W + LIVE_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr_we,
  input  logic                            mask_we,
  input  logic [2:0]                      mask_idx,
  input  logic [DATA_W-1:0]               wdata,
  input  logic [EVT_W-1:0]                evt_set,
  input  logic [LIVE_W-1:0]               live,
  output logic [STAT_W-1:0]               status,
  output logic [NUM_IRQ-1:0][DATA_W-1:0]  masks,
  output logic [NUM_IRQ-1:0]              irq
);

  logic [EVT_W-1:0] sticky_q;
  logic [EVT_W-1:0] clr_bits;

  assign clr_bits = clr_we ? wdata[EVT_W-1:0] : '0;
  assign status   = {live, sticky_q};

  always_ff @(posedge clk) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= (sticky_q & ~clr_bits) | evt_set;
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)                               masks[g] <= '0;
      else if (mask_we && (mask_idx == 3'(g)))  masks[g] <= wdata;
    end
    assign irq[g] = |(DATA_W'(status) & masks[g]);
  end

endmodule

// File: rtl/card_regs.sv
module card_regs
  import cardreg_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int CTRL_W     = 8,
  parameter int LEN_W      = 16,
  parameter int CMD_W      = 11,
  parameter int RCMD_W     = 6,
  parameter int RESP_WORDS = 4,
  parameter int EVT_W      = 11,
  parameter int LIVE_W     = 11,
  parameter int NUM_IRQ    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_sel,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic                          bus_err,
  output logic [CTRL_W-1:0]             power_out,
  output logic [CTRL_W-1:0]             clkdiv_out,
  output logic [DATA_W-1:0]             cmd_arg,
  output logic [CMD_W-1:0]              cmd_value,
  output logic                          cmd_start,
  output logic [DATA_W-1:0]             data_timer,
  output logic [CTRL_W-1:0]             data_ctrl,
  output logic                          data_start,
  input  logic                          resp_load,
  input  logic [RCMD_W-1:0]             resp_cmd,
  input  logic [RESP_WORDS*DATA_W-1:0]  resp_data,
  input  logic [EVT_W-1:0]              evt_set,
  input  logic [LIVE_W-1:0]             live_status,
  input  logic                          byte_done,
  input  logic [DATA_W-1:0]             fifo_rdata,
  input  logic                          fifo_empty,
  output logic                          fifo_push,
  output logic                          fifo_pop,
  output logic [DATA_W-1:0]             fifo_wdata,
  output logic [NUM_IRQ-1:0]            irq
);

  localparam int STAT_W = EVT_W + LIVE_W;
  localparam int RIDX_W = (RESP_WORDS > 1) ? $clog2(RESP_WORDS) : 1;

  reg_sel_e                          sel;
  logic [2:0]                        idx;
  logic                              wr_en;
  logic                              rd_en;
  logic                              clr_we;
  logic                              mask_we;
  logic                              dcnt_load;
  logic [LEN_W-1:0]                  dlen_q;
  logic [LEN_W-1:0]                  dcnt_q;
  logic [RCMD_W-1:0]                 rcmd_q;
  logic [RESP_WORDS-1:0][DATA_W-1:0] resp_q;
  logic [STAT_W-1:0]                 status_w;
  logic [NUM_IRQ-1:0][DATA_W-1:0]    masks_w;

  assign wr_en   = bus_sel && bus_wr;
  assign rd_en   = bus_sel && !bus_wr;
  assign clr_we  = wr_en && (sel == RS_CLR);
  assign mask_we = wr_en && (sel == RS_MASK);

  cardreg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel),
    .idx  (idx)
  );

  cardreg_cfg #(
    .DATA_W(DATA_W), .CTRL_W(CTRL_W), .LEN_W(LEN_W), .CMD_W(CMD_W),
    .RCMD_W(RCMD_W), .RESP_WORDS(RESP_WORDS)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (wr_en),
    .sel        (sel),
    .wdata      (bus_wdata),
    .resp_load  (resp_load),
    .resp_cmd   (resp_cmd),
    .resp_data  (resp_data),
    .byte_done  (byte_done),
    .power_q    (power_out),
    .clk_q      (clkdiv_out),
    .arg_q      (cmd_arg),
    .cmd_q      (cmd_value),
    .dtimer_q   (data_timer),
    .dlen_q     (dlen_q),
    .dctrl_q    (data_ctrl),
    .dcnt_q     (dcnt_q),
    .rcmd_q     (rcmd_q),
    .resp_q     (resp_q),
    .cmd_start  (cmd_start),
    .data_start (data_start),
    .dcnt_load  (dcnt_load)
  );

  cardreg_status #(
    .DATA_W(DATA_W), .EVT_W(EVT_W), .LIVE_W(LIVE_W), .NUM_IRQ(NUM_IRQ)
  ) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_we   (clr_we),
    .mask_we  (mask_we),
    .mask_idx (idx),
    .wdata    (bus_wdata),
    .evt_set  (evt_set),
    .live     (live_status),
    .status   (status_w),
    .masks    (masks_w),
    .irq      (irq)
  );

  // FIFO strobes toward the external data path.
  assign fifo_pop   = rd_en && (sel == RS_FIFO) && !fifo_empty;
  assign fifo_push  = wr_en && (sel == RS_FIFO) && (dcnt_q != '0);
  assign fifo_wdata = bus_wdata;
  assign bus_err    = bus_sel && (sel == RS_NONE);

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (sel)
        RS_POWER:  bus_rdata = DATA_W'(power_out);
        RS_CLOCK:  bus_rdata = DATA_W'(clkdiv_out);
        RS_ARG:    bus_rdata = cmd_arg;
        RS_CMD:    bus_rdata = DATA_W'(cmd_value);
        RS_RCMD:   bus_rdata = DATA_W'(rcmd_q);
        RS_RESP:   bus_rdata = resp_q[idx[RIDX_W-1:0]];
        RS_DTIMER: bus_rdata = data_timer;
        RS_DLEN:   bus_rdata = DATA_W'(dlen_q);
        RS_DCTRL:  bus_rdata = DATA_W'(data_ctrl);
        RS_DCNT:   bus_rdata = DATA_W'(dcnt_q);
        RS_STAT:   bus_rdata = DATA_W'(status_w);
        RS_MASK:   bus_rdata = masks_w[idx[0]];
        RS_FCNT:   bus_rdata = DATA_W'(fifo_words(32'(dcnt_q)));
        RS_FIFO:   bus_rdata = fifo_empty ? '0 : fifo_rdata;
        RS_ID:     bus_rdata = DATA_W'(id_byte(idx));
        default:   bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/cardreg_checker.sv
module cardreg_checker #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 16,
  parameter int EVT_W   = 11,
  parameter int STAT_W  = 22,
  parameter int NUM_IRQ = 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bus_sel,
  input logic                           bus_wr,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic [DATA_W-1:0]              bus_wdata,
  input logic [DATA_W-1:0]              bus_rdata,
  input logic                           bus_err,
  input logic                           cmd_start,
  input logic [EVT_W-1:0]               evt_set,
  input logic                           byte_done,
  input logic                           fifo_empty,
  input logic                           fifo_push,
  input logic                           fifo_pop,
  input logic [NUM_IRQ-1:0]             irq,
  input logic [LEN_W-1:0]               dcnt,
  input logic                           dcnt_load,
  input logic                           clr_we,
  input logic [STAT_W-1:0]              status,
  input logic [NUM_IRQ-1:0][DATA_W-1:0] masks
);

  p_push_needs_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> (bus_sel && bus_wr && (dcnt != '0)));

  p_pop_not_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (bus_sel && !bus_wr && !fifo_empty));

  p_cmd_start_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> $past(bus_sel && bus_wr && (bus_addr == ADDR_W'(12'h00C)) && bus_wdata[10]));

  p_clear_effect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((status[EVT_W-1:0] & $past(bus_wdata[EVT_W-1:0] & ~evt_set)) == '0));

  p_event_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((status[EVT_W-1:0] & $past(evt_set)) == $past(evt_set)));

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !dcnt_load && (dcnt != '0)) |=> (dcnt == $past(dcnt) - LEN_W'(1)));

  p_err_reads_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));

  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (masks == '0) |-> (irq == '0));

endmodule

bind card_regs cardreg_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .EVT_W(EVT_W),
  .STAT_W(EVT_W + LIVE_W), .NUM_IRQ(NUM_IRQ)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_err    (bus_err),
  .cmd_start  (cmd_start),
  .evt_set    (evt_set),
  .byte_done  (byte_done),
  .fifo_empty (fifo_empty),
  .fifo_push  (fifo_push),
  .fifo_pop   (fifo_pop),
  .irq        (irq),
  .dcnt       (dcnt_q),
  .dcnt_load  (dcnt_load),
  .clr_we     (clr_we),
  .status     (status_w),
  .masks      (masks_w)
);

// File: tb/tb_card_regs.sv
module tb_card_regs;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 1'b0;
  logic         bus_wr = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_err;
  logic [7:0]   power_out, clkdiv_out, data_ctrl;
  logic [31:0]  cmd_arg, data_timer, fifo_wdata;
  logic [10:0]  cmd_value;
  logic         cmd_start, data_start, fifo_push, fifo_pop;
  logic         resp_load = 1'b0;
  logic [5:0]   resp_cmd = '0;
  logic [127:0] resp_data = '0;
  logic [10:0]  evt_set = '0;
  logic [10:0]  live_status = '0;
  logic         byte_done = 1'b0;
  logic [31:0]  fifo_rdata = '0;
  logic         fifo_empty = 1'b1;
  logic [1:0]   irq;

  int checks = 0;
  int fails  = 0;

  logic [31:0] rd_val;
  logic        rd_err;
  logic        rd_pop;
  logic        wr_push;
  logic        wr_err;
  logic [31:0] wr_fdata;

  always #5 clk = ~clk;

  card_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .power_out(power_out), .clkdiv_out(clkdiv_out),
    .cmd_arg(cmd_arg), .cmd_value(cmd_value), .cmd_start(cmd_start),
    .data_timer(data_timer), .data_ctrl(data_ctrl), .data_start(data_start),
    .resp_load(resp_load), .resp_cmd(resp_cmd), .resp_data(resp_data),
    .evt_set(evt_set), .live_status(live_status), .byte_done(byte_done),
    .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty), .fifo_push(fifo_push),
    .fifo_pop(fifo_pop), .fifo_wdata(fifo_wdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_read(input logic [11:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    rd_val = bus_rdata; rd_err = bus_err; rd_pop = fifo_pop;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1;
    wr_push = fifo_push; wr_err = bus_err; wr_fdata = fifo_wdata;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic expect_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    bus_read(a);
    check(tag, rd_val, exp);
  endtask

  task automatic pulse_evt(input logic [10:0] bits);
    @(negedge clk); evt_set = bits;
    @(negedge clk); evt_set = '0;
  endtask

  task automatic pulse_byte();
    @(negedge clk); byte_done = 1'b1;
    @(negedge clk); byte_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [11:0] offs [16] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010,
      12'h014, 12'h018, 12'h01C, 12'h020, 12'h024, 12'h028, 12'h02C,
      12'h030, 12'h034, 12'h03C, 12'h040};
    for (int i = 0; i < 16; i++) expect_rd("R1 reset value", offs[i], 32'h0);
    expect_rd("R1 reset fifo count", 12'h048, 32'h0);
    check("R1 irq after reset", 32'(irq), 32'h0);
  endtask

  task automatic t_widths();
    bus_write(12'h000, 32'hFFFF_FFA5); expect_rd("R2 power 8 bits", 12'h000, 32'hA5);
    bus_write(12'h004, 32'h1234_5678); expect_rd("R2 clock 8 bits", 12'h004, 32'h78);
    bus_write(12'h008, 32'hDEAD_BEEF); expect_rd("R2 argument", 12'h008, 32'hDEAD_BEEF);
    bus_write(12'h024, 32'hCAFE_F00D); expect_rd("R2 timer", 12'h024, 32'hCAFE_F00D);
    bus_write(12'h028, 32'hABCD_1234); expect_rd("R2 length 16 bits", 12'h028, 32'h1234);
    bus_write(12'h02C, 32'h0000_01FE); expect_rd("R2 data ctrl 8 bits", 12'h02C, 32'hFE);
    check("R2 power port", 32'(power_out), 32'hA5);
  endtask

  task automatic t_command();
    bus_write(12'h00C, 32'hFFFF_F4C5);
    check("R3 go pulse", 32'(cmd_start), 32'h1);
    @(posedge clk); #1;
    check("R3 go pulse one cycle", 32'(cmd_start), 32'h0);
    expect_rd("R3 go bit self clears", 12'h00C, 32'h0C5);
    bus_write(12'h00C, 32'h0000_0045);
    check("R3 no pulse without go", 32'(cmd_start), 32'h0);
    expect_rd("R3 plain command", 12'h00C, 32'h045);
  endtask

  task automatic t_response();
    @(negedge clk);
    resp_load = 1'b1; resp_cmd = 6'h2A;
    resp_data = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
    @(negedge clk);
    resp_load = 1'b0; resp_data = '0; resp_cmd = '0;
    expect_rd("R4 response index", 12'h010, 32'h2A);
    expect_rd("R4 word 0", 12'h014, 32'h1111_1111);
    expect_rd("R4 word 1", 12'h018, 32'h2222_2222);
    expect_rd("R4 word 2", 12'h01C, 32'h3333_3333);
    expect_rd("R4 word 3", 12'h020, 32'h4444_4444);
  endtask

  task automatic t_status();
    live_status = 11'h5A5;
    pulse_evt(11'h7FF);
    expect_rd("R5 status layout", 12'h034, (32'h5A5 << 11) | 32'h7FF);
    bus_write(12'h038, 32'hFFFF_F00F);
    expect_rd("R6 clear low bits only", 12'h034, (32'h5A5 << 11) | 32'h7F0);
    expect_rd("R6 clear reads zero", 12'h038, 32'h0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h038; bus_wdata = 32'h30;
    evt_set = 11'h010;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; evt_set = '0;
    expect_rd("R5 set wins over clear", 12'h034, (32'h5A5 << 11) | 32'h7D0);
    live_status = '0;
    bus_write(12'h038, 32'h7FF);
    expect_rd("R6 all cleared", 12'h034, 32'h0);
  endtask

  task automatic t_irq();
    bus_write(12'h03C, 32'h0000_0100);
    bus_write(12'h040, 32'h0000_0004);
    expect_rd("R7 mask1 readback", 12'h040, 32'h4);
    check("R7 irq idle", 32'(irq), 32'h0);
    pulse_evt(11'h100);
    check("R7 irq0 only", 32'(irq), 32'h1);
    pulse_evt(11'h004);
    check("R7 both lines", 32'(irq), 32'h3);
    bus_write(12'h038, 32'h100);
    check("R7 irq0 drops on clear", 32'(irq), 32'h2);
    bus_write(12'h040, 32'h0);
    check("R7 irq1 drops on mask", 32'(irq), 32'h0);
    bus_write(12'h038, 32'h7FF);
    bus_write(12'h03C, 32'h0000_1000);
    @(negedge clk); live_status = 11'h002;
    @(negedge clk);
    check("R7 live bit through mask", 32'(irq), 32'h1);
    live_status = '0;
    bus_write(12'h03C, 32'h0);
  endtask

  task automatic t_data();
    bus_write(12'h028, 32'h6);
    bus_write(12'h02C, 32'h3);
    check("R8 data start pulse", 32'(data_start), 32'h1);
    expect_rd("R8 count loaded", 12'h030, 32'h6);
    expect_rd("R9 fifo count of 6", 12'h048, 32'h2);
    pulse_byte();
    expect_rd("R8 count step", 12'h030, 32'h5);
    pulse_byte(); pulse_byte();
    expect_rd("R9 fifo count of 3", 12'h048, 32'h1);
    pulse_byte(); pulse_byte(); pulse_byte(); pulse_byte();
    expect_rd("R8 count holds at zero", 12'h030, 32'h0);
    expect_rd("R9 fifo count of 0", 12'h048, 32'h0);
    bus_write(12'h028, 32'h9);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h02C; bus_wdata = 32'h1;
    byte_done = 1'b1;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; byte_done = 1'b0;
    expect_rd("R8 load wins", 12'h030, 32'h9);
    expect_rd("R9 fifo count of 9", 12'h048, 32'h3);
    bus_write(12'h028, 32'hFFFF);
    bus_write(12'h02C, 32'h1);
    expect_rd("R9 fifo count at full length", 12'h048, 32'h4000);
  endtask

  task automatic t_fifo();
    bus_write(12'h028, 32'h0);
    bus_write(12'h02C, 32'h1);
    bus_write(12'h080, 32'hAAAA_0001);
    check("R11 no push at zero count", 32'(wr_push), 32'h0);
    bus_write(12'h028, 32'h4);
    bus_write(12'h02C, 32'h1);
    bus_write(12'h09C, 32'h1122_3344);
    check("R11 push strobe", 32'(wr_push), 32'h1);
    check("R11 push data", wr_fdata, 32'h1122_3344);
    fifo_empty = 1'b1; fifo_rdata = 32'h55AA;
    bus_read(12'h080);
    check("R10 empty read value", rd_val, 32'h0);
    check("R10 empty read no pop", 32'(rd_pop), 32'h0);
    fifo_empty = 1'b0;
    bus_read(12'h0BC);
    check("R10 read value", rd_val, 32'h55AA);
    check("R10 pop strobe", 32'(rd_pop), 32'h1);
    fifo_rdata = 32'h0BAD_F00D;
    bus_read(12'h084);
    check("R10 alias read", rd_val, 32'h0BAD_F00D);
    fifo_empty = 1'b1;
  endtask

  task automatic t_ident();
    logic [7:0] exp_id [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++)
      expect_rd("R12 id byte", 12'hFE0 + 12'(i * 4), 32'(exp_id[i]));
  endtask

  task automatic t_undefined();
    bus_read(12'h044);
    check("R13 undefined read zero", rd_val, 32'h0);
    check("R13 undefined read err", 32'(rd_err), 32'h1);
    bus_read(12'h7FC);
    check("R13 high hole err", 32'(rd_err), 32'h1);
    bus_read(12'h002);
    check("R13 unaligned err", 32'(rd_err), 32'h1);
    bus_read(12'h000);
    check("R13 defined no err", 32'(rd_err), 32'h0);
    bus_write(12'h044, 32'hFFFF_FFFF);
    check("R13 undefined write err", 32'(wr_err), 32'h1);
    bus_write(12'h001, 32'h0000_0011);
    expect_rd("R13 undefined write no effect", 12'h000, 32'hA5);
    pulse_evt(11'h020);
    bus_write(12'h034, 32'h0);
    check("R13 read-only write no err", 32'(wr_err), 32'h0);
    expect_rd("R13 read-only status untouched", 12'h034, 32'h20);
    bus_write(12'h030, 32'h0);
    expect_rd("R13 read-only count untouched", 12'h030, 32'h4);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_widths();
    t_command();
    t_response();
    t_status();
    t_irq();
    t_data();
    t_fifo();
    t_ident();
    t_undefined();
    finish_run();
  end

endmodule